// File: doc/BRIEF.md
# Critical Pulse-Width Search Controller

This controller runs a built-in self-test that finds, cell by cell, the shortest word-line pulse width at which a chosen event first becomes the likely outcome. Depending on the access pattern, the event is a read upset, a completed write or a correctly sensed read. It walks an address range and, for each address, sweeps a pulse-width codeword upward. At every codeword it repeats a fixed number of trials. A trial writes the known initial value with the widest pulse, reads it back with a string of minimum-width pulses to confirm it, optionally waits, applies the stress pulses of the programmed pattern, then reads the cell back again the same gentle way.

The array is driven through a simple access port: one request per pulse, carrying address, codeword, direction and write data. The array acknowledges each request and returns the sensed bit. The controller counts the trials in which the event occurred. The first codeword where that count is more than half the trial count is the threshold. One result per address goes out on a valid/ready stream.

Top module: `pulse_sweep_bist`

## Requirements
- R1: After reset `res_valid`, `acc_req` and `done` are 0 and the controller waits for `start`.
- R2: `start` latches the address range, pattern, sweep limits, initial value, hold, repeat and gap settings only while idle or done; a `start` during a run is ignored and changes no result.
- R3: Every trial begins with a write of the latched initial value at codeword all-ones to the address under test, so the number of all-ones writes equals the number of trials run.
- R4: Each readback is exactly `RB_N` consecutive reads at codeword 0, and the value taken is the sensed bit of the last of them.
- R5: If the readback after the initial write differs from the initial value, the address is reported at once with status 2 and the codeword in use.
- R6: Each codeword is tried `TRIALS` times; the reported threshold (status 0) is the first codeword whose event count exceeds `TRIALS`/2, so a count of exactly half is not a crossing.
- R7: If no codeword up to the upper sweep limit crosses, the address is reported with status 1 and the upper limit as codeword.
- R8: Pattern codes: 0 one write of the inverted initial value; 1 two such writes; 2 one read; 3 a write of the initial value then a read; 4 repeated reads; 5 one read whose sensed bit is judged; 6 and 7 act as 2. All stress pulses use the swept codeword. The event is a readback equal to the inverted initial value for 0 and 1, a first-stress sensed bit equal to the initial value for 5, and a readback differing from the initial value otherwise.
- R9: Pattern 4 issues `cfg_reps` reads (0 counts as 1); between consecutive stress pulses of any pattern `acc_req` stays low for exactly `cfg_gap` cycles.
- R10: Between the confirming readback and the first stress pulse, `acc_req` stays low for exactly `cfg_hold` cycles.
- R11: Results go out in ascending address order; `res_valid` stays high with stable fields until `res_ready`, and no access is issued while a result waits.
- R12: `done` rises the cycle after the last result is taken, stays high until the next `start` and falls when that `start` is taken.
- R13: `acc_req` stays high with stable address, codeword, direction and data until `acc_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run with the cfg_* values |
| cfg_addr_lo | input | AW | First address |
| cfg_addr_hi | input | AW | Last address |
| cfg_pat | input | 3 | Access pattern code |
| cfg_code_lo | input | CW | First codeword of the sweep |
| cfg_code_hi | input | CW | Last codeword of the sweep |
| cfg_init | input | 1 | Initial cell value |
| cfg_hold | input | HW | Idle cycles before the stress pulses |
| cfg_reps | input | RW | Read count for pattern 4 |
| cfg_gap | input | HW | Idle cycles between stress pulses |
| done | output | 1 | Run finished |
| acc_req | output | 1 | Pulse request |
| acc_we | output | 1 | Request is a write |
| acc_wdata | output | 1 | Write data |
| acc_addr | output | AW | Cell address |
| acc_code | output | CW | Pulse-width codeword |
| acc_ack | input | 1 | Request completed |
| acc_rdata | input | 1 | Sensed bit, valid with acc_ack |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken |
| res_addr | output | AW | Result address |
| res_pat | output | 3 | Result pattern code |
| res_code | output | CW | Threshold or last codeword |
| res_status | output | 2 | 0 found, 1 not found, 2 initial value not confirmed |

## Verification
The bench models a cell whose write succeeds on every other attempt one code below its write threshold, so a count of exactly half must not be taken as a crossing; a design comparing with greater-or-equal reports one code too low. The same model makes two back-to-back writes succeed one code earlier and lets repeated reads at one code lower the upset threshold, so a design that miscounts stress pulses or repeats reports the wrong codeword. Readback reads at code 0 return the true bit only on the last of the run, so a design keeping an earlier read sees every initial value as unconfirmed. A stuck cell, a sweep limit below the threshold, held-off result acceptance, a stray start mid-run and the idle spacing of hold and gap are each checked against what a faulty controller would show: a wrong status, a lost or reordered result, or a wrong idle length.

// File: rtl/pulse_sweep_bist.sv
module pulse_sweep_bist #(
  parameter int AW     = 6,
  parameter int CW     = 5,
  parameter int TRIALS = 128,
  parameter int RB_N   = 3,
  parameter int RW     = 3,
  parameter int HW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_addr_lo,
  input  logic [AW-1:0] cfg_addr_hi,
  input  logic [2:0]    cfg_pat,
  input  logic [CW-1:0] cfg_code_lo,
  input  logic [CW-1:0] cfg_code_hi,
  input  logic          cfg_init,
  input  logic [HW-1:0] cfg_hold,
  input  logic [RW-1:0] cfg_reps,
  input  logic [HW-1:0] cfg_gap,
  output logic          done,
  output logic          acc_req,
  output logic          acc_we,
  output logic          acc_wdata,
  output logic [AW-1:0] acc_addr,
  output logic [CW-1:0] acc_code,
  input  logic          acc_ack,
  input  logic          acc_rdata,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_addr,
  output logic [2:0]    res_pat,
  output logic [CW-1:0] res_code,
  output logic [1:0]    res_status
);
  localparam int TCW = $clog2(TRIALS + 1);
  localparam int RBW = $clog2(RB_N + 1);
  localparam int SW  = (RW > RBW) ? RW : RBW;
  localparam logic [CW-1:0]  CMAX  = '1;
  localparam logic [TCW:0]   TLIM  = (TCW+1)'(TRIALS);
  localparam logic [TCW-1:0] TLAST = TCW'(TRIALS - 1);
  localparam logic [SW-1:0]  RBL   = SW'(RB_N - 1);

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_RB, S_WAIT, S_STRESS, S_OUT, S_DONE} st_t;
  st_t st;

  logic [AW-1:0]  addr, addr_hi;
  logic [CW-1:0]  code, code_lo, code_hi;
  logic [2:0]     pat;
  logic           init, post, sense_ok, hit;
  logic [HW-1:0]  hold, gap, wcnt;
  logic [RW-1:0]  reps;
  logic [TCW-1:0] trial, hits, hits_n;
  logic [SW-1:0]  sub, n_ops;
  logic [1:0]     status;
  logic [TCW:0]   dbl;

  assign n_ops = (pat == 3'd4) ? ((reps == '0) ? SW'(1) : SW'(reps))
               : (pat == 3'd1 || pat == 3'd3) ? SW'(2) : SW'(1);
  wire op_we = (pat == 3'd0) || (pat == 3'd1) || (pat == 3'd3 && sub == '0);
  wire op_wd = (pat == 3'd3) ? init : ~init;

  always_comb begin
    case (pat)
      3'd0, 3'd1: hit = (acc_rdata == ~init);
      3'd5:       hit = sense_ok;
      default:    hit = (acc_rdata != init);
    endcase
  end

  assign hits_n = hits + TCW'(hit);
  assign dbl    = {hits_n, 1'b0};
  wire crossed  = dbl > TLIM;

  assign acc_req   = (st == S_INIT) || (st == S_RB) || (st == S_STRESS);
  assign acc_we    = (st == S_INIT) || (st == S_STRESS && op_we);
  assign acc_wdata = (st == S_INIT) ? init : op_wd;
  assign acc_code  = (st == S_INIT) ? CMAX : (st == S_STRESS) ? code : '0;
  assign acc_addr  = addr;

  assign res_valid  = (st == S_OUT);
  assign res_addr   = addr;
  assign res_pat    = pat;
  assign res_code   = code;
  assign res_status = status;
  assign done       = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr <= '0; addr_hi <= '0; code <= '0; code_lo <= '0; code_hi <= '0;
      pat <= '0; init <= 1'b0; hold <= '0; gap <= '0; reps <= '0;
      trial <= '0; hits <= '0; sub <= '0; wcnt <= '0;
      post <= 1'b0; sense_ok <= 1'b0; status <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          addr <= cfg_addr_lo; addr_hi <= cfg_addr_hi;
          code <= cfg_code_lo; code_lo <= cfg_code_lo; code_hi <= cfg_code_hi;
          pat <= cfg_pat; init <= cfg_init; hold <= cfg_hold; gap <= cfg_gap; reps <= cfg_reps;
          trial <= '0; hits <= '0;
          st <= S_INIT;
        end
        S_INIT: if (acc_ack) begin
          sub <= '0; post <= 1'b0; st <= S_RB;
        end
        S_RB: if (acc_ack) begin
          if (sub != RBL) begin
            sub <= sub + SW'(1);
          end else if (!post) begin
            sub <= '0;
            if (acc_rdata != init) begin
              status <= 2'd2; st <= S_OUT;
            end else if (hold != '0) begin
              wcnt <= hold; st <= S_WAIT;
            end else begin
              st <= S_STRESS;
            end
          end else if (trial == TLAST) begin
            trial <= '0; hits <= '0;
            if (crossed) begin
              status <= 2'd0; st <= S_OUT;
            end else if (code == code_hi) begin
              status <= 2'd1; st <= S_OUT;
            end else begin
              code <= code + CW'(1); st <= S_INIT;
            end
          end else begin
            trial <= trial + TCW'(1); hits <= hits_n; st <= S_INIT;
          end
        end
        S_WAIT: begin
          wcnt <= wcnt - HW'(1);
          if (wcnt == HW'(1)) st <= S_STRESS;
        end
        S_STRESS: if (acc_ack) begin
          if (sub == '0) sense_ok <= (acc_rdata == init);
          if (sub == n_ops - SW'(1)) begin
            sub <= '0; post <= 1'b1; st <= S_RB;
          end else begin
            sub <= sub + SW'(1);
            if (gap != '0) begin
              wcnt <= gap; st <= S_WAIT;
            end
          end
        end
        S_OUT: if (res_ready) begin
          trial <= '0; hits <= '0;
          if (addr == addr_hi) st <= S_DONE;
          else begin
            addr <= addr + AW'(1); code <= code_lo; st <= S_INIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pulse_sweep_bist_chk.sv
module pulse_sweep_bist_chk #(
  parameter int AW = 6,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_req,
  input logic          acc_ack,
  input logic          acc_we,
  input logic          acc_wdata,
  input logic [AW-1:0] acc_addr,
  input logic [CW-1:0] acc_code,
  input logic          res_valid,
  input logic          res_ready,
  input logic [AW-1:0] res_addr,
  input logic [2:0]    res_pat,
  input logic [CW-1:0] res_code,
  input logic [1:0]    res_status,
  input logic          done
);
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req && $stable(acc_addr) && $stable(acc_code)
                            && $stable(acc_we) && $stable(acc_wdata));

  assert_res_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) && $stable(res_pat)
                                && $stable(res_code) && $stable(res_status));

  assert_no_access_with_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !acc_req);

  assert_quiet_when_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !acc_req && !res_valid);

  assert_status_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_status != 2'd3);
endmodule

bind pulse_sweep_bist pulse_sweep_bist_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_ack(acc_ack), .acc_we(acc_we),
  .acc_wdata(acc_wdata), .acc_addr(acc_addr), .acc_code(acc_code),
  .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr), .res_pat(res_pat),
  .res_code(res_code), .res_status(res_status), .done(done)
);

// File: tb/pulse_sweep_bist_bench.sv
`timescale 1ns/1ps
module pulse_sweep_bist_bench;
  localparam int AW = 3, CW = 4, TR = 8, RBN = 3, RW = 3, HW = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] cfg_addr_lo = 0, cfg_addr_hi = 0;
  logic [2:0] cfg_pat = 0;
  logic [CW-1:0] cfg_code_lo = 0, cfg_code_hi = 0;
  logic cfg_init = 0;
  logic [HW-1:0] cfg_hold = 0, cfg_gap = 0;
  logic [RW-1:0] cfg_reps = 0;
  logic done, acc_req, acc_we, acc_wdata, acc_ack, acc_rdata, res_valid, res_ready;
  logic [AW-1:0] acc_addr, res_addr;
  logic [CW-1:0] acc_code, res_code;
  logic [2:0] res_pat;
  logic [1:0] res_status;

  always #4 clk = ~clk;

  pulse_sweep_bist #(.AW(AW), .CW(CW), .TRIALS(TR), .RB_N(RBN), .RW(RW), .HW(HW)) u_pulse_sweep_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
    .cfg_pat(cfg_pat), .cfg_code_lo(cfg_code_lo), .cfg_code_hi(cfg_code_hi), .cfg_init(cfg_init),
    .cfg_hold(cfg_hold), .cfg_reps(cfg_reps), .cfg_gap(cfg_gap), .done(done),
    .acc_req(acc_req), .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_addr(acc_addr),
    .acc_code(acc_code), .acc_ack(acc_ack), .acc_rdata(acc_rdata),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr), .res_pat(res_pat),
    .res_code(res_code), .res_status(res_status));

  int tests = 0, fails = 0;
  task automatic chk(input bit ok, input string what, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  // behavioural cell array
  logic mem [8];
  int wthr [8], rthr [8], athr [8];
  bit stuck [8];
  int ma, mc, r0 = 0, kr = 0, lastrc = 0;
  bit upm = 0, wtog = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      acc_ack <= 0; acc_rdata <= 0;
    end else begin
      acc_ack <= 0;
      if (acc_req && !acc_ack) begin
        acc_ack <= 1;
        ma = int'(acc_addr);
        mc = int'(acc_code);
        if (acc_we) begin
          r0 = 0; kr = 0; lastrc = 0; upm = 0;
          if (!stuck[ma]) begin
            if (mc == 15 || mc >= wthr[ma]) mem[ma] = acc_wdata;
            else if (mc == wthr[ma] - 1) begin
              if (wtog) mem[ma] = acc_wdata;
              wtog = !wtog;
            end
          end
        end else if (mc == 0) begin
          r0++; kr = 0; lastrc = 0;
          acc_rdata <= (r0 >= RBN) ? mem[ma] : !mem[ma];
        end else begin
          r0 = 0;
          if (mc == lastrc) begin if (kr < 3) kr++; end
          else kr = 1;
          lastrc = mc;
          acc_rdata <= (mc >= athr[ma]) ? mem[ma] : !mem[ma];
          if (!upm && mc >= rthr[ma] - (kr - 1)) begin mem[ma] = !mem[ma]; upm = 1; end
        end
      end
    end
  end

  // port monitors
  bit running = 0, pend = 0;
  logic [CW-1:0] p_code; logic [AW-1:0] p_addr; logic p_we, p_wd;
  int maxw, badinit, run0, badrb, idle, nh, ng, badidle, badhs;
  int cur_hold = 0, cur_gap = 0;
  bit cur_init = 0;

  always @(negedge clk) begin
    if (running) begin
      if (pend && !(acc_req && acc_code == p_code && acc_addr == p_addr && acc_we == p_we && acc_wdata == p_wd))
        badhs++;
      pend = acc_req && !acc_ack;
      p_code = acc_code; p_addr = acc_addr; p_we = acc_we; p_wd = acc_wdata;
      if (acc_ack) begin
        if (acc_we && acc_code == 4'd15) begin
          maxw++;
          if (acc_wdata != cur_init) badinit++;
        end
        if (!acc_we && acc_code == 0) run0++;
        else begin
          if (run0 != 0 && run0 != RBN) badrb++;
          run0 = 0;
        end
      end
      if (!acc_req && !res_valid && !done) idle++;
      else if (idle != 0) begin
        if (idle == cur_hold) nh++;
        else if (idle == cur_gap) ng++;
        else badidle++;
        idle = 0;
      end
    end
  end

  int exp_code [8], exp_stat [8];

  task automatic set_exp(input int a, input int t, input int lo, input int hi);
    if (t <= hi) begin exp_code[a] = (t < lo) ? lo : t; exp_stat[a] = 0; end
    else begin exp_code[a] = hi; exp_stat[a] = 1; end
  endtask

  task automatic start_run(input int alo, input int ahi, input int pat, input int clo, input int chi,
                           input bit ini, input int hold, input int reps, input int gap);
    @(negedge clk);
    cfg_addr_lo = AW'(alo); cfg_addr_hi = AW'(ahi); cfg_pat = 3'(pat);
    cfg_code_lo = CW'(clo); cfg_code_hi = CW'(chi); cfg_init = ini;
    cfg_hold = HW'(hold); cfg_reps = RW'(reps); cfg_gap = HW'(gap);
    cur_init = ini; cur_hold = hold; cur_gap = gap;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(done == 0, "R12 done falls on start", int'(done), 0);
    maxw = 0; badinit = 0; run0 = 0; badrb = 0; idle = 0; nh = 0; ng = 0; badidle = 0; badhs = 0;
    pend = 0; running = 1;
  endtask

  task automatic collect(input int alo, input int ahi, input int pat, input int clo, input int chi,
                         input int bp, input string tag, output int trials);
    trials = 0;
    for (int a = alo; a <= ahi; a++) begin
      while (!res_valid) @(negedge clk);
      chk(int'(res_addr) == a, {tag, " R11 address order"}, int'(res_addr), a);
      chk(int'(res_pat) == pat, {tag, " R8 pattern echo"}, int'(res_pat), pat);
      chk(int'(res_status) == exp_stat[a], {tag, " R6 status"}, int'(res_status), exp_stat[a]);
      chk(int'(res_code) == exp_code[a], {tag, " R6 threshold code"}, int'(res_code), exp_code[a]);
      if (exp_stat[a] == 0) trials += (exp_code[a] - clo + 1) * TR;
      else if (exp_stat[a] == 1) trials += (chi - clo + 1) * TR;
      else trials += 1;
      if (bp > 0 && a == alo) begin
        int hc = 0;
        for (int i = 0; i < bp; i++) begin
          @(negedge clk);
          if (!res_valid || acc_req || int'(res_addr) != a || int'(res_code) != exp_code[a]) hc++;
        end
        chk(hc == 0, {tag, " R11 result held under back-pressure"}, hc, 0);
      end
      res_ready = 1;
      @(negedge clk);
      res_ready = 0;
    end
    chk(done == 1, {tag, " R12 done after last result"}, int'(done), 1);
    running = 0;
    chk(maxw == trials, {tag, " R3 one full-width init write per trial"}, maxw, trials);
    chk(badinit == 0, {tag, " R3 init write data"}, badinit, 0);
    chk(badrb == 0, {tag, " R4 readback run length"}, badrb, 0);
    chk(badhs == 0, {tag, " R13 request held until ack"}, badhs, 0);
  endtask

  task automatic t_reset;
    chk(res_valid == 0, "R1 res_valid after reset", int'(res_valid), 0);
    chk(acc_req == 0, "R1 acc_req after reset", int'(acc_req), 0);
    chk(done == 0, "R1 done after reset", int'(done), 0);
  endtask

  task automatic t_single_write;
    int n;
    wthr[0] = 6; wthr[1] = 9; wthr[2] = 4;
    for (int a = 0; a < 3; a++) begin rthr[a] = 15; athr[a] = 1; set_exp(a, wthr[a], 2, 12); end
    start_run(0, 2, 0, 2, 12, 0, 0, 1, 0);
    collect(0, 2, 0, 2, 12, 0, "single write R6 half not crossing", n);
  endtask

  task automatic t_write_twice;
    int n;
    wthr[3] = 7; wthr[4] = 5;
    for (int a = 3; a < 5; a++) begin rthr[a] = 15; athr[a] = 1; set_exp(a, wthr[a] - 1, 2, 12); end
    start_run(3, 4, 1, 2, 12, 1, 0, 1, 2);
    collect(3, 4, 1, 2, 12, 0, "write-after-write R8", n);
    chk(ng == n && badidle == 0, "R9 gap between two writes", ng, n);
  endtask

  task automatic t_read_stab;
    int n;
    rthr[0] = 5; rthr[1] = 8; wthr[0] = 1; wthr[1] = 1;
    set_exp(0, 5, 1, 12); set_exp(1, 8, 1, 12);
    start_run(0, 1, 2, 1, 12, 1, 0, 1, 0);
    collect(0, 1, 2, 1, 12, 0, "single read R8", n);
    rthr[2] = 7; wthr[2] = 1; set_exp(2, 7, 1, 12);
    start_run(2, 2, 3, 1, 12, 0, 0, 1, 0);
    collect(2, 2, 3, 1, 12, 0, "read-after-write R8", n);
  endtask

  task automatic t_read_repeat;
    int n;
    rthr[5] = 9; rthr[6] = 6; wthr[5] = 1; wthr[6] = 1;
    set_exp(5, 7, 1, 12); set_exp(6, 4, 1, 12);
    start_run(5, 6, 4, 1, 12, 0, 5, 3, 2);
    collect(5, 6, 4, 1, 12, 0, "read-after-read R9", n);
    chk(nh == n, "R10 hold before stress", nh, n);
    chk(ng == 2 * n, "R9 gaps between repeated reads", ng, 2 * n);
    chk(badidle == 0, "R9 R10 no other idle length", badidle, 0);
    set_exp(5, 9, 1, 12);
    start_run(5, 5, 4, 1, 12, 0, 0, 0, 0);
    collect(5, 5, 4, 1, 12, 0, "zero repeats as one R9", n);
  endtask

  task automatic t_access;
    int n;
    athr[0] = 3; athr[1] = 10; athr[2] = 6; athr[3] = 1;
    for (int a = 0; a < 4; a++) begin rthr[a] = 15; wthr[a] = 1; set_exp(a, athr[a], 1, 12); end
    start_run(0, 3, 5, 1, 12, 1, 0, 1, 0);
    collect(0, 3, 5, 1, 12, 0, "read access R8", n);
  endtask

  task automatic t_missing;
    int n;
    wthr[1] = 5; wthr[2] = 3; wthr[3] = 13;
    for (int a = 1; a < 4; a++) begin rthr[a] = 15; athr[a] = 1; end
    stuck[2] = 1; mem[2] = 1;
    set_exp(1, 5, 2, 10); set_exp(3, 13, 2, 10);
    exp_code[2] = 2; exp_stat[2] = 2;
    start_run(1, 3, 0, 2, 10, 0, 0, 1, 0);
    collect(1, 3, 0, 2, 10, 0, "R5 R7 stuck cell and no crossing", n);
    stuck[2] = 0;
  endtask

  task automatic t_stall_and_restart;
    int n;
    rthr[0] = 4; rthr[1] = 6; wthr[0] = 1; wthr[1] = 1;
    set_exp(0, 4, 1, 8); set_exp(1, 6, 1, 8);
    start_run(0, 1, 2, 1, 8, 0, 0, 1, 0);
    repeat (40) @(negedge clk);
    cfg_pat = 3'd0; cfg_addr_lo = 3'd5; cfg_code_lo = 4'd9; start = 1;
    @(negedge clk);
    start = 0;
    collect(0, 1, 2, 1, 8, 20, "R2 ignored start", n);
    repeat (5) @(negedge clk);
    chk(done == 1, "R12 done stays high", int'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R11 watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 8; a++) begin mem[a] = 0; wthr[a] = 1; rthr[a] = 15; athr[a] = 1; stuck[a] = 0; end
    res_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_single_write;
    t_write_twice;
    t_read_stab;
    t_read_repeat;
    t_access;
    t_missing;
    t_stall_and_restart;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule